// File: doc/BRIEF.md
# Keyed Program-Memory Write Unlock Controller

This block sits on a small CPU register bus and guards the start of a program-memory programming cycle. Software must prove intent before a cycle begins. It sets a write-enable bit in the control register. It then writes the two key bytes 55h and AAh, in that order, to a key register that stores nothing. Its next bus write must set the write-start bit. The block rejects any start request that breaks this order.

While a cycle runs, the block holds the CPU stall output high. A down-counter stands in for the cell programming time. When the count expires, the write-start bit clears itself and a one-cycle completion pulse is raised. The pulse can feed an interrupt flag.

The block has two kinds of reset:
- The power-on reset clears everything.
- The warm resets (master-clear and watchdog) clear the control state but keep a write-error flag. A warm reset that cuts a running cycle short sets this flag, so software can decide whether to rewrite.

The block also holds the 22-bit table pointer that addresses program memory. Software writes the pointer one byte at a time.

The bus is a plain register interface. A write or read is accepted in the cycle it is presented, with no back-pressure. Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.

Top module: `nvm_write_guard`

## Requirements
- R1: After the power-on reset, the control register reads 00h, `cpu_stall`, `prog_done` and `read_req` are low, and `tbl_ptr` is zero.
- R2: The control register (address 0) has this layout: bit 7 memory select, bit 6 configuration select, bit 5 unused, bit 4 erase select, bit 3 write error, bit 2 write enable, bit 1 write start, bit 0 read start. Bits 7, 6, 4 and 2 read back as written, and bit 5 always reads 0.
- R3: The key register (address 1) has no storage. It reads 00h, and writing it changes no other register.
- R4: A programming cycle starts, and `cpu_stall` rises in the cycle after the write, when all three of these hold:
  - the control register is written with bit 1 set;
  - write enable was already 1 before that write;
  - the two bus writes just before it were 55h and then AAh to the key register.
- R5: Any other write between the steps cancels the sequence, and the start request is then ignored with no stall. This includes a wrong key value, a pointer write, or a control write without bit 1. A key write of 55h always restarts the sequence at its first step.
- R6: If write enable is 0 before the start write, the start is ignored with no stall. This holds even if the same write sets write enable.
- R7: `cpu_stall` stays high for exactly PROG_CYCLES cycles, and bit 1 reads 1 during that time. Then bit 1 clears and `prog_done` pulses high for one cycle.
- R8: Bus writes presented while `cpu_stall` is high are ignored. Reads are still served.
- R9: A master-clear or watchdog reset pulse during a cycle ends the stall without `prog_done` and sets bit 3. Every warm reset clears write enable, the select bits, the sequence and the table pointer.
- R10: Bit 3 is cleared by the power-on reset or by a control write with bit 3 at 0. A warm reset that arrives with no cycle running keeps bit 3, and software cannot set bit 3 by writing 1.
- R11: The table pointer is written and read as a low byte (address 2, bits 7:0), a high byte (address 3, bits 15:8) and an upper byte (address 4, bits 21:16). Bits 7:6 of the upper byte read 0, and the full pointer drives `tbl_ptr`.
- R12: Writing bit 0 of the control register as 1 raises `read_req` for exactly one cycle. Bit 0 always reads back 0.
- R13: `bus_rdata` takes the addressed value one cycle after `bus_rd` and keeps it while no read is presented. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mclr_req | input | 1 | Master-clear warm reset, synchronous, active high |
| wdt_req | input | 1 | Watchdog warm reset, synchronous, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read strobe |
| cpu_stall | output | 1 | High while a programming cycle runs |
| prog_done | output | 1 | One-cycle pulse when a cycle completes |
| read_req | output | 1 | One-cycle pulse requesting a program-memory read |
| tbl_ptr | output | 22 | Table pointer for program-memory addressing |

## Verification
The bench checks each way the unlock order can be broken: a wrong key value, a pointer write, a plain control write between the key writes and the start, and a start that sets write enable in the same write. A design that tracks too little state would stall the CPU in one of these cases. The bench also checks a repeated 55h, which a design that is too strict would wrongly reject. It counts stall cycles exactly, so an off-by-one in the counter shows up as a stall that is one cycle short or one cycle long. It covers the error flag from all sides: set when a warm reset cuts a cycle short, kept across a warm reset with no cycle running, cleared only by a write of 0 or by power-on. A design that treated all resets alike, or let software set the flag, would fail one of these reads.

// File: rtl/nvm_wg_pkg.sv
package nvm_wg_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_KEY      = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PTR_BASE = 3'd2;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

  // control register bit positions
  localparam int B_MSEL   = 7;
  localparam int B_CFG    = 6;
  localparam int B_ERASE  = 4;
  localparam int B_WERR   = 3;
  localparam int B_WEN    = 2;
  localparam int B_WSTART = 1;
  localparam int B_RSTART = 0;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FIRST = 2'd1,
    SEQ_ARMED = 2'd2
  } seq_e;

endpackage

// File: rtl/nvm_wg_unlock.sv
module nvm_wg_unlock
  import nvm_wg_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);

  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_fire) begin
      // any write that is not the expected next step returns to idle
      st_d = SEQ_IDLE;
      if (addr == ADR_KEY) begin
        if (wdata == KEY_FIRST) begin
          st_d = SEQ_FIRST;
        end else if (wdata == KEY_SECOND && st_q == SEQ_FIRST) begin
          st_d = SEQ_ARMED;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q <= SEQ_IDLE;
    end else if (warm_rst) begin
      st_q <= SEQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign armed = (st_q == SEQ_ARMED);

endmodule

// File: rtl/nvm_wg_prog_timer.sv
module nvm_wg_prog_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else if (warm_rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        cnt_q <= LOAD;
      end
    end
  end

endmodule

// File: rtl/nvm_wg_tblptr.sv
module nvm_wg_tblptr
  import nvm_wg_pkg::*;
#(
  parameter int PTR_W = 22,
  parameter int NB    = (PTR_W + 7) / 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [NB*8-1:0]   rd_bytes_o
);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam int LO = g * 8;
    localparam int BW = (PTR_W - LO >= 8) ? 8 : (PTR_W - LO);
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(int'(ADR_PTR_BASE) + g);

    logic [BW-1:0] q;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        q <= '0;
      end else if (warm_rst) begin
        q <= '0;
      end else if (wr_fire && addr == MY_ADR) begin
        q <= wdata[BW-1:0];
      end
    end

    assign ptr_o[LO +: BW]       = q;
    assign rd_bytes_o[g*8 +: 8]  = 8'(q);
  end

endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
  import nvm_wg_pkg::*;
#(
  parameter int PROG_CYCLES = 16,
  parameter int PTR_W       = 22
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mclr_req,
  input  logic              wdt_req,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_stall,
  output logic              prog_done,
  output logic              read_req,
  output logic [PTR_W-1:0]  tbl_ptr
);

  localparam int PTR_BYTES = (PTR_W + 7) / 8;

  logic warm_rst;
  logic wr_fire;
  logic ctrl_wr;
  logic armed;
  logic busy;
  logic start;
  logic [PTR_BYTES*8-1:0] ptr_bytes;

  logic msel_q, cfg_q, erase_q, werr_q, wen_q, rreq_q;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign warm_rst = mclr_req | wdt_req;
  // writes are dropped while the CPU is stalled or held in warm reset
  assign wr_fire  = bus_wr & ~busy & ~warm_rst;
  assign ctrl_wr  = wr_fire && (bus_addr == ADR_CTRL);
  assign start    = ctrl_wr & bus_wdata[B_WSTART] & armed & wen_q;

  nvm_wg_unlock u_unlock (
    .clk      (clk),
    .por_n    (por_n),
    .warm_rst (warm_rst),
    .wr_fire  (wr_fire),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .armed    (armed)
  );

  nvm_wg_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk      (clk),
    .por_n    (por_n),
    .warm_rst (warm_rst),
    .start    (start),
    .busy     (busy),
    .done     (prog_done)
  );

  nvm_wg_tblptr #(.PTR_W(PTR_W), .NB(PTR_BYTES)) u_ptr (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst   (warm_rst),
    .wr_fire    (wr_fire),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .ptr_o      (tbl_ptr),
    .rd_bytes_o (ptr_bytes)
  );

  // control bits cleared by every reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      msel_q  <= 1'b0;
      cfg_q   <= 1'b0;
      erase_q <= 1'b0;
      wen_q   <= 1'b0;
      rreq_q  <= 1'b0;
    end else if (warm_rst) begin
      msel_q  <= 1'b0;
      cfg_q   <= 1'b0;
      erase_q <= 1'b0;
      wen_q   <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      rreq_q <= ctrl_wr & bus_wdata[B_RSTART];
      if (ctrl_wr) begin
        msel_q  <= bus_wdata[B_MSEL];
        cfg_q   <= bus_wdata[B_CFG];
        erase_q <= bus_wdata[B_ERASE];
        wen_q   <= bus_wdata[B_WEN];
      end
    end
  end

  // error flag: only power-on clears it by reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      werr_q <= 1'b0;
    end else if (warm_rst) begin
      if (busy) begin
        werr_q <= 1'b1;
      end
    end else if (ctrl_wr && !bus_wdata[B_WERR]) begin
      werr_q <= 1'b0;
    end
  end

  assign ctrl_view = {msel_q, cfg_q, 1'b0, erase_q, werr_q, wen_q, busy, 1'b0};

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADR_CTRL) begin
      rd_mux = ctrl_view;
    end
    for (int i = 0; i < PTR_BYTES; i++) begin
      if (bus_addr == ADDR_W'(int'(ADR_PTR_BASE) + i)) begin
        rd_mux = ptr_bytes[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign cpu_stall = busy;
  assign read_req  = rreq_q;

endmodule

// File: rtl/nvm_write_guard_chk.sv
module nvm_write_guard_chk
  import nvm_wg_pkg::*;
#(
  parameter int PROG_CYCLES = 16,
  parameter int PTR_W       = 22
) (
  input logic              clk,
  input logic              por_n,
  input logic              mclr_req,
  input logic              wdt_req,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cpu_stall,
  input logic              prog_done,
  input logic              read_req,
  input logic [PTR_W-1:0]  tbl_ptr,
  input logic              armed,
  input logic              wen_q,
  input logic              werr_q
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_q <= '0;
    end else begin
      run_q <= cpu_stall ? run_q + 1 : '0;
    end
  end

  // R4: a cycle starts only from an armed, enabled start write
  a_r4_start_needs_unlock: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_stall) |-> $past(armed && wen_q && bus_wr && bus_addr == ADR_CTRL && bus_wdata[B_WSTART]));

  // R7: stall never exceeds the programmed length
  a_r7_stall_bounded: assert property (@(posedge clk) disable iff (!por_n)
    cpu_stall |-> (run_q < PROG_CYCLES));

  // R7: completion follows exactly PROG_CYCLES stall cycles
  a_r7_done_after_full_run: assert property (@(posedge clk) disable iff (!por_n)
    prog_done |-> (run_q == PROG_CYCLES) && !cpu_stall);

  // R9: warm reset during a cycle sets the error flag and ends the stall
  a_r9_abort_sets_error: assert property (@(posedge clk) disable iff (!por_n)
    ((mclr_req || wdt_req) && cpu_stall) |=> (werr_q && !cpu_stall && !prog_done));

  // R8: writes during a stall leave the pointer untouched
  a_r8_ptr_frozen_in_stall: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_stall && bus_wr && !mclr_req && !wdt_req) |=> $stable(tbl_ptr));

  // R2: unused control bit reads 0
  a_r2_unused_bit_zero: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && bus_addr == ADR_CTRL) |=> !bus_rdata[5]);

  // R3: key register reads 0
  a_r3_key_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && bus_addr == ADR_KEY) |=> (bus_rdata == '0));

  // R12: read request is a single-cycle pulse
  a_r12_read_req_pulse: assert property (@(posedge clk) disable iff (!por_n)
    read_req |=> !read_req);

endmodule

bind nvm_write_guard nvm_write_guard_chk #(.PROG_CYCLES(PROG_CYCLES), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .mclr_req  (mclr_req),
  .wdt_req   (wdt_req),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cpu_stall (cpu_stall),
  .prog_done (prog_done),
  .read_req  (read_req),
  .tbl_ptr   (tbl_ptr),
  .armed     (armed),
  .wen_q     (wen_q),
  .werr_q    (werr_q)
);

// File: tb/nvm_write_guard_bench.sv
`timescale 1ns/1ps
module nvm_write_guard_bench;

  localparam int P = 16;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        mclr_req = 1'b0;
  logic        wdt_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cpu_stall;
  logic        prog_done;
  logic        read_req;
  logic [21:0] tbl_ptr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t exp_q[$];
  logic rd_seen = 1'b0;

  always #2 clk = ~clk;

  nvm_write_guard #(.PROG_CYCLES(P), .PTR_W(22)) u_nvm_write_guard (
    .clk(clk), .por_n(por_n), .mclr_req(mclr_req), .wdt_req(wdt_req),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .prog_done(prog_done),
    .read_req(read_req), .tbl_ptr(tbl_ptr)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data is due
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", 0, 0);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check(bus_rdata == it.exp, it.tag, int'(bus_rdata), int'(it.exp));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic unlock_start(input logic [7:0] ctrl);
    wr(3'd1, 8'h55);
    wr(3'd1, 8'hAA);
    wr(3'd0, ctrl);
  endtask

  task automatic expect_no_stall(input string tag);
    for (int i = 0; i < 3; i++) begin
      check(cpu_stall == 1'b0, tag, int'(cpu_stall), 0);
      @(negedge clk);
    end
  endtask

  // called at the negedge right after the start write
  task automatic run_cycle(input string tag);
    int n = 0;
    while (cpu_stall && n < P + 8) begin
      n++;
      @(negedge clk);
    end
    check(n == P, {tag, " R7 stall length"}, n, P);
    check(prog_done == 1'b1, {tag, " R7 done pulse"}, int'(prog_done), 1);
    @(negedge clk);
    check(prog_done == 1'b0, {tag, " R7 done one cycle"}, int'(prog_done), 0);
  endtask

  task automatic warm_pulse(input bit use_wdt);
    @(negedge clk);
    if (use_wdt) wdt_req = 1'b1; else mclr_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0; mclr_req = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cpu_stall == 0, "R1 stall", int'(cpu_stall), 0);
    check(prog_done == 0, "R1 done", int'(prog_done), 0);
    check(read_req == 0, "R1 read_req", int'(read_req), 0);
    check(tbl_ptr == 0, "R1 tbl_ptr", int'(tbl_ptr), 0);
    rd(3'd0, 8'h00, "R1 ctrl reset");

    // R11 table pointer bytes
    wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'hFF);
    check(tbl_ptr == 22'h3F1234, "R11 tbl_ptr", int'(tbl_ptr), 'h3F1234);
    rd(3'd4, 8'h3F, "R11 upper byte");
    rd(3'd2, 8'h34, "R11 low byte");
    rd(3'd3, 8'h12, "R11 high byte");
    // R13 read data holds
    repeat (2) @(negedge clk);
    check(bus_rdata == 8'h12, "R13 rdata hold", int'(bus_rdata), 'h12);
    rd(3'd6, 8'h00, "R13 unmapped");

    // R3 key register
    wr(3'd1, 8'h77);
    rd(3'd1, 8'h00, "R3 key reads 0");
    rd(3'd0, 8'h00, "R3 ctrl untouched");

    // R2 layout
    wr(3'd0, 8'hF4);
    rd(3'd0, 8'hD4, "R2 readback");
    wr(3'd0, 8'h84);

    // R4 + R7 good cycle
    unlock_start(8'h86);
    check(cpu_stall == 1, "R4 stall rises", int'(cpu_stall), 1);
    run_cycle("R4");
    rd(3'd0, 8'h84, "R7 start bit cleared");

    // R8 writes ignored during stall, reads served
    unlock_start(8'h86);
    wr(3'd2, 8'h00);
    rd(3'd0, 8'h86, "R7 start bit reads 1 in stall");
    while (cpu_stall) @(negedge clk);
    rd(3'd2, 8'h34, "R8 ptr write ignored");

    // R5 broken sequences
    wr(3'd1, 8'h55); wr(3'd1, 8'h12); wr(3'd1, 8'hAA); wr(3'd0, 8'h86);
    expect_no_stall("R5 wrong key");
    wr(3'd1, 8'h55); wr(3'd3, 8'h12); wr(3'd1, 8'hAA); wr(3'd0, 8'h86);
    expect_no_stall("R5 ptr write between");
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h84); wr(3'd0, 8'h86);
    expect_no_stall("R5 ctrl write between");
    rd(3'd0, 8'h84, "R5 ctrl after breaks");
    wr(3'd1, 8'h55);
    unlock_start(8'h86);
    check(cpu_stall == 1, "R5 repeated 55 restarts", int'(cpu_stall), 1);
    run_cycle("R5");

    // R6 enable not previously set
    wr(3'd0, 8'h80);
    unlock_start(8'h86);
    expect_no_stall("R6 enable clear");
    rd(3'd0, 8'h84, "R6 ctrl after ignored start");

    // R12 read request pulse
    wr(3'd0, 8'h85);
    check(read_req == 1, "R12 pulse", int'(read_req), 1);
    @(negedge clk);
    check(read_req == 0, "R12 pulse ends", int'(read_req), 0);
    rd(3'd0, 8'h84, "R12 bit0 reads 0");

    // R9 abort by master clear
    unlock_start(8'h86);
    repeat (3) @(negedge clk);
    warm_pulse(1'b0);
    check(cpu_stall == 0, "R9 stall ends", int'(cpu_stall), 0);
    check(prog_done == 0, "R9 no done", int'(prog_done), 0);
    check(tbl_ptr == 0, "R9 ptr cleared", int'(tbl_ptr), 0);
    rd(3'd0, 8'h08, "R9 error set, enable cleared");

    // R10 error flag rules
    warm_pulse(1'b1);
    rd(3'd0, 8'h08, "R10 kept over idle warm reset");
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h00, "R10 cleared by write 0");
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h00, "R10 write 1 does not set");
    wr(3'd0, 8'h04);
    unlock_start(8'h06);
    repeat (2) @(negedge clk);
    warm_pulse(1'b1);
    rd(3'd0, 8'h08, "R9 watchdog abort sets error");
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    rd(3'd0, 8'h00, "R10 power-on clears error");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule